// File: doc/BRIEF.md
# Hardware Address Breakpoint Unit

This block watches the memory accesses of a CPU and flags those that hit programmed addresses. Two address registers, a control register and a status register are reached through a simple register port. In dual-address mode an access hits when its address equals either address register. In span mode it hits when the address lies between the two registers, both ends included. Span mode exists only when the parameter `RANGE_EN` is non-zero.

A two-bit access filter selects which accesses count. Filter bit 0 enables reads and filter bit 1 enables writes. A source bit selects what is compared. At 0, the data-path address with its read and write strobes is compared. At 1, the instruction-fetch address is compared, and each fetch counts as a read.

Every hit kind sets its own sticky status bit. A status bit is cleared by writing 1 to it. A small watch state machine (`W_OFF`, `W_WATCH`) follows the control enable bit. While it is in `W_WATCH`, the unit raises `halt_req` to the debug controller in the same cycle as any access that sets a status bit.

The register map is:

| Address (`reg_sel`) | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | status | read, write 1 to clear |
| 2 | address 0 | read/write |
| 3 | address 1 | read/write |

Control register fields:

| Bit | Field | Meaning |
|---|---|---|
| 0 | enable | unit enable |
| 1 | span | 1 selects span mode |
| 2 | source | 0 compares data accesses, 1 compares instruction fetches |
| 4:3 | filter | bit 0 enables reads, bit 1 enables writes |

Status register bits:

| Bit | Hit kind |
|---|---|
| 0 | read at address 0 |
| 1 | write at address 0 |
| 2 | read at address 1 |
| 3 | write at address 1 |
| 4 | read inside the span |
| 5 | write inside the span |

Watch state machine:

| Transition | From | To | Condition |
|---|---|---|---|
| `ARM` | `W_OFF` | `W_WATCH` | the enable bit reads 1 |
| `DISARM` | `W_WATCH` | `W_OFF` | the enable bit reads 0 |

Each transition takes one clock edge after the control register changes.

Top module: `brkpt_unit`

## Requirements
- R1: After reset, all four registers read 0 and `halt_req` is 0.
- R2: With span=0, an enabled access whose address equals address 0 sets status bit 0 (read) or bit 1 (write). An enabled access whose address equals address 1 sets bit 2 (read) or bit 3 (write). Other addresses set nothing.
- R3: Filter bit 0 (control bit 3) gates read hits and filter bit 1 (control bit 4) gates write hits. A disabled kind never sets a status bit.
- R4: With span=1 and `RANGE_EN`≠0, a read with address 0 ≤ address ≤ address 1 sets status bit 4, and such a write sets bit 5. Both bounds are inclusive.
- R5: With span=1 and `RANGE_EN`≠0, status bits 0 to 3 never set. When address 0 is greater than address 1, no access sets any bit.
- R6: With source=1, only the fetch address qualified by `fetch_strobe` is compared, and a fetch counts as a read. With source=0, only `dat_addr` qualified by `dat_rd`/`dat_wr` is compared.
- R7: Status bits stay set until written with 1 at `reg_sel`=1. Bits written with 0 keep their value. A set in the same cycle as a clear wins.
- R8: `halt_req` is 1 in exactly the cycles in which an access would set a status bit and the watch machine is in `W_WATCH`. With enable=0 it stays 0.
- R9: With `RANGE_EN`=0, the span bit has no effect: matching follows R2, and status bits 4 and 5 stay 0.
- R10: The control, address 0 and address 1 registers read back the last value written, with the control register zero-extended above bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 address 0, 3 address 1 |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Read data of the selected register (combinational) |
| dat_addr | input | AW | Data access address |
| dat_rd | input | 1 | Data read strobe |
| dat_wr | input | 1 | Data write strobe |
| fetch_addr | input | AW | Instruction fetch address |
| fetch_strobe | input | 1 | Instruction fetch strobe |
| halt_req | output | 1 | Halt request to the debug controller |

## Verification
`halt_req` is combinational in the access cycle, so the bench samples it 1 ns after the falling edge on which it drives the access. The status bits are registered, so they are read back through the register port on the next falling edge, one rising edge after the access. The watch machine lags a control write by one more edge, so the bench idles two cycles after each configuration before any access. Each swept access is followed by a write-1 clear of the status register, so every result belongs to exactly one access.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;

    localparam int ST_W = 6;

    localparam int ST_A0_RD  = 0;
    localparam int ST_A0_WR  = 1;
    localparam int ST_A1_RD  = 2;
    localparam int ST_A1_WR  = 3;
    localparam int ST_RNG_RD = 4;
    localparam int ST_RNG_WR = 5;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_ADR0 = 2'd2;
    localparam logic [1:0] SEL_ADR1 = 2'd3;

    typedef struct packed {
        logic [1:0] acc;   // [1] write enable, [0] read enable
        logic       inst;  // compare fetches instead of data
        logic       rng;   // span mode
        logic       en;    // unit enable
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic {
        W_OFF   = 1'b0,
        W_WATCH = 1'b1
    } watch_e;

endpackage

// File: rtl/brkpt_regs.sv
module brkpt_regs
    import brkpt_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [1:0]      reg_sel,
    input  logic [AW-1:0]   reg_wdata,
    input  logic [ST_W-1:0] set_vec,
    output ctrl_t           ctrl_q,
    output logic [AW-1:0]   adr0_q,
    output logic [AW-1:0]   adr1_q,
    output logic [ST_W-1:0] status_q,
    output logic [AW-1:0]   rdata
);

    localparam int CTRL_PAD = AW - CTRL_W;
    localparam int STAT_PAD = AW - ST_W;

    logic [ST_W-1:0] clr_vec;
    logic [ST_W-1:0] status_d;

    always_comb begin
        clr_vec = '0;
        if (reg_we && reg_sel == SEL_STAT) begin
            clr_vec = reg_wdata[ST_W-1:0];
        end
        // a new hit outranks a clear in the same cycle
        status_d = (status_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            adr0_q   <= '0;
            adr1_q   <= '0;
            status_q <= '0;
        end else begin
            status_q <= status_d;
            if (reg_we) begin
                unique case (reg_sel)
                    SEL_CTRL: ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
                    SEL_ADR0: adr0_q <= reg_wdata;
                    SEL_ADR1: adr1_q <= reg_wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_CTRL: rdata = {{CTRL_PAD{1'b0}}, ctrl_q};
            SEL_STAT: rdata = {{STAT_PAD{1'b0}}, status_q};
            SEL_ADR0: rdata = adr0_q;
            default:  rdata = adr1_q;
        endcase
    end

endmodule

// File: rtl/brkpt_src.sv
module brkpt_src #(
    parameter int AW = 16
) (
    input  logic          use_fetch,
    input  logic [AW-1:0] dat_addr,
    input  logic          dat_rd,
    input  logic          dat_wr,
    input  logic [AW-1:0] fetch_addr,
    input  logic          fetch_strobe,
    output logic [AW-1:0] cmp_addr,
    output logic          cmp_rd,
    output logic          cmp_wr
);

    always_comb begin
        if (use_fetch) begin
            cmp_addr = fetch_addr;
            cmp_rd   = fetch_strobe;
            cmp_wr   = 1'b0;
        end else begin
            cmp_addr = dat_addr;
            cmp_rd   = dat_rd;
            cmp_wr   = dat_wr;
        end
    end

endmodule

// File: rtl/brkpt_cmp.sv
module brkpt_cmp
    import brkpt_pkg::*;
#(
    parameter int AW       = 16,
    parameter int RANGE_EN = 1
) (
    input  ctrl_t           ctrl,
    input  logic [AW-1:0]   adr0,
    input  logic [AW-1:0]   adr1,
    input  logic [AW-1:0]   cmp_addr,
    input  logic            cmp_rd,
    input  logic            cmp_wr,
    output logic [ST_W-1:0] hit
);

    logic eq0;
    logic eq1;
    logic span_on;
    logic in_span;
    logic rd_ok;
    logic wr_ok;

    assign eq0   = (cmp_addr == adr0);
    assign eq1   = (cmp_addr == adr1);
    assign rd_ok = cmp_rd && ctrl.acc[0];
    assign wr_ok = cmp_wr && ctrl.acc[1];

    generate
        if (RANGE_EN != 0) begin : g_span
            assign span_on = ctrl.rng;
            assign in_span = (cmp_addr >= adr0) && (cmp_addr <= adr1);
        end else begin : g_nospan
            assign span_on = 1'b0;
            assign in_span = 1'b0;
        end
    endgenerate

    always_comb begin
        hit = '0;
        if (span_on) begin
            hit[ST_RNG_RD] = rd_ok && in_span;
            hit[ST_RNG_WR] = wr_ok && in_span;
        end else begin
            hit[ST_A0_RD] = rd_ok && eq0;
            hit[ST_A0_WR] = wr_ok && eq0;
            hit[ST_A1_RD] = rd_ok && eq1;
            hit[ST_A1_WR] = wr_ok && eq1;
        end
    end

endmodule

// File: rtl/brkpt_unit.sv
module brkpt_unit
    import brkpt_pkg::*;
#(
    parameter int AW       = 16,
    parameter int RANGE_EN = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic [AW-1:0] dat_addr,
    input  logic          dat_rd,
    input  logic          dat_wr,
    input  logic [AW-1:0] fetch_addr,
    input  logic          fetch_strobe,
    output logic          halt_req
);

    ctrl_t           ctrl_q;
    logic [AW-1:0]   adr0_q;
    logic [AW-1:0]   adr1_q;
    logic [ST_W-1:0] status_q;
    logic [ST_W-1:0] hit;
    logic [AW-1:0]   cmp_addr;
    logic            cmp_rd;
    logic            cmp_wr;
    watch_e          state_q;
    watch_e          state_d;

    brkpt_regs #(.AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .set_vec  (hit),
        .ctrl_q   (ctrl_q),
        .adr0_q   (adr0_q),
        .adr1_q   (adr1_q),
        .status_q (status_q),
        .rdata    (reg_rdata)
    );

    brkpt_src #(.AW(AW)) u_src (
        .use_fetch   (ctrl_q.inst),
        .dat_addr    (dat_addr),
        .dat_rd      (dat_rd),
        .dat_wr      (dat_wr),
        .fetch_addr  (fetch_addr),
        .fetch_strobe(fetch_strobe),
        .cmp_addr    (cmp_addr),
        .cmp_rd      (cmp_rd),
        .cmp_wr      (cmp_wr)
    );

    brkpt_cmp #(.AW(AW), .RANGE_EN(RANGE_EN)) u_cmp (
        .ctrl    (ctrl_q),
        .adr0    (adr0_q),
        .adr1    (adr1_q),
        .cmp_addr(cmp_addr),
        .cmp_rd  (cmp_rd),
        .cmp_wr  (cmp_wr),
        .hit     (hit)
    );

    // next state: ARM / DISARM
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_OFF:   if (ctrl_q.en)  state_d = W_WATCH;
            W_WATCH: if (!ctrl_q.en) state_d = W_OFF;
            default: state_d = W_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            W_WATCH: halt_req = |hit;
            default: halt_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/brkpt_unit_chk.sv
module brkpt_unit_chk #(
    parameter int RANGE_EN = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       halt_req,
    input logic [5:0] status,
    input logic [4:0] ctrl,
    input logic       reg_we,
    input logic [1:0] reg_sel
);

    logic clr_cyc;
    assign clr_cyc = reg_we && (reg_sel == 2'd1);

    // R8: a halt always leaves a status bit behind
    p_halt_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> (status != 6'd0));

    // R8: no halt while the enable bit is low
    p_halt_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> ctrl[0]);

    // R7: without a clear, set bits stay set
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_cyc |=> ((status & $past(status)) == $past(status)));

    // R5: span mode never sets address-equality bits
    p_span_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[1] && RANGE_EN != 0) |=> ((status[3:0] & ~$past(status[3:0])) == 4'd0));

    // R3: read-only filter never sets write bits
    p_rdonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[4:3] == 2'b01) |=> ((status & ~$past(status) & 6'b101010) == 6'd0));

    // R6: fetches never set write bits
    p_fetch_nowr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[2] |=> ((status & ~$past(status) & 6'b101010) == 6'd0));

    // R9: span status stays clear when span logic is absent
    always @(posedge clk) begin
        if (rst_n && RANGE_EN == 0) begin
            p_nospan_r9: assert (status[5:4] == 2'b00);
        end
    end

endmodule

bind brkpt_unit brkpt_unit_chk #(.RANGE_EN(RANGE_EN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .halt_req(halt_req),
    .status  (status_q),
    .ctrl    (ctrl_q),
    .reg_we  (reg_we),
    .reg_sel (reg_sel)
);

// File: tb/brkpt_unit_bench.sv
`timescale 1ns/1ps
module brkpt_unit_bench;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] dat_addr = '0;
    logic          dat_rd = 1'b0;
    logic          dat_wr = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          fetch_strobe = 1'b0;
    logic [AW-1:0] rdata1;
    logic [AW-1:0] rdata0;
    logic          halt1;
    logic          halt0;

    int n_chk  = 0;
    int n_fail = 0;

    logic [AW-1:0] c_a0, c_a1;
    logic          c_en, c_rng, c_inst;
    logic [1:0]    c_acc;

    always #2.5 clk = ~clk;

    brkpt_unit #(.AW(AW), .RANGE_EN(1)) u_brkpt_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(rdata1), .dat_addr(dat_addr),
        .dat_rd(dat_rd), .dat_wr(dat_wr), .fetch_addr(fetch_addr),
        .fetch_strobe(fetch_strobe), .halt_req(halt1)
    );

    brkpt_unit #(.AW(AW), .RANGE_EN(0)) u_brkpt_unit_nospan (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(rdata0), .dat_addr(dat_addr),
        .dat_rd(dat_rd), .dat_wr(dat_wr), .fetch_addr(fetch_addr),
        .fetch_strobe(fetch_strobe), .halt_req(halt0)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] expect_stat(input logic span_present, input logic [AW-1:0] a,
                                               input logic rd, input logic wr, input logic fe);
        logic [5:0] s = '0;
        logic r = c_inst ? fe : rd;
        logic w = c_inst ? 1'b0 : wr;
        logic rok = r && c_acc[0];
        logic wok = w && c_acc[1];
        if (c_rng && span_present) begin
            if (a >= c_a0 && a <= c_a1) begin
                s[4] = rok;
                s[5] = wok;
            end
        end else begin
            s[0] = rok && (a == c_a0);
            s[1] = wok && (a == c_a0);
            s[2] = rok && (a == c_a1);
            s[3] = wok && (a == c_a1);
        end
        return s;
    endfunction

    task automatic wr_reg(input logic [1:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic configure(input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                             input logic en, input logic rng, input logic inst,
                             input logic [1:0] acc);
        c_a0 = a0; c_a1 = a1; c_en = en; c_rng = rng; c_inst = inst; c_acc = acc;
        wr_reg(2'd2, a0);
        wr_reg(2'd3, a1);
        wr_reg(2'd0, {3'b000, acc, inst, rng, en});
        wr_reg(2'd1, '1);
        repeat (2) @(negedge clk);
    endtask

    task automatic access(input logic [AW-1:0] a, input int kind, input string tag);
        logic [5:0] e1, e0;
        @(negedge clk);
        dat_addr = a; fetch_addr = a;
        dat_rd = (kind == 0); dat_wr = (kind == 1); fetch_strobe = (kind == 2);
        e1 = expect_stat(1'b1, a, dat_rd, dat_wr, fetch_strobe);
        e0 = expect_stat(1'b0, a, dat_rd, dat_wr, fetch_strobe);
        #1;
        check(halt1 == (c_en && e1 != 0), tag, halt1, (c_en && e1 != 0));
        check(halt0 == (c_en && e0 != 0), "R9", halt0, (c_en && e0 != 0));
        @(negedge clk);
        dat_rd = 1'b0; dat_wr = 1'b0; fetch_strobe = 1'b0; reg_sel = 2'd1;
        #1;
        check(rdata1 == {2'b00, e1}, tag, rdata1, {2'b00, e1});
        check(rdata0 == {2'b00, e0}, "R9", rdata0, {2'b00, e0});
        reg_we = 1'b1; reg_wdata = '1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < 256; a++) begin
            for (int k = 0; k < 3; k++) begin
                access(AW'(a), k, tag);
            end
        end
    endtask

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check(halt1 == 1'b0, "R1", halt1, 0);
        for (int s = 0; s < 4; s++) begin
            reg_sel = 2'(s);
            #0.1;
            check(rdata1 == '0, "R1", rdata1, 0);
        end
        rst_n = 1'b1;

        // R10: readback
        configure(8'h5A, 8'hC3, 1'b1, 1'b0, 1'b0, 2'b11);
        @(negedge clk); reg_sel = 2'd0; #1;
        check(rdata1 == 8'h19, "R10", rdata1, 8'h19);
        reg_sel = 2'd2; #0.1;
        check(rdata1 == 8'h5A, "R10", rdata1, 8'h5A);
        reg_sel = 2'd3; #0.1;
        check(rdata1 == 8'hC3, "R10", rdata1, 8'hC3);

        // R2: dual-address equality
        configure(8'h23, 8'hA7, 1'b1, 1'b0, 1'b0, 2'b11);
        sweep("R2");

        // R3: read-only and write-only filters
        configure(8'h23, 8'hA7, 1'b1, 1'b0, 1'b0, 2'b01);
        sweep("R3");
        configure(8'h23, 8'hA7, 1'b1, 1'b0, 1'b0, 2'b10);
        sweep("R3");

        // R4: inclusive span
        configure(8'h40, 8'h4F, 1'b1, 1'b1, 1'b0, 2'b11);
        sweep("R4");

        // R5: inverted span matches nothing
        configure(8'h50, 8'h40, 1'b1, 1'b1, 1'b0, 2'b11);
        sweep("R5");

        // R6: fetch source, span and dual
        configure(8'h10, 8'h12, 1'b1, 1'b1, 1'b1, 2'b11);
        sweep("R6");
        configure(8'h10, 8'hF2, 1'b1, 1'b0, 1'b1, 2'b11);
        sweep("R6");

        // R8: disabled unit never halts
        configure(8'h23, 8'hA7, 1'b0, 1'b0, 1'b0, 2'b11);
        sweep("R8");

        // R7: sticky, partial clear, set beats clear
        configure(8'h23, 8'hA7, 1'b1, 1'b0, 1'b0, 2'b11);
        @(negedge clk); dat_addr = 8'h23; dat_rd = 1'b1;
        @(negedge clk); dat_rd = 1'b0; dat_addr = 8'hA7; dat_wr = 1'b1;
        @(negedge clk); dat_wr = 1'b0;
        repeat (2) @(negedge clk);
        reg_sel = 2'd1; #1;
        check(rdata1 == 8'h09, "R7", rdata1, 8'h09);
        wr_reg(2'd1, 8'h01);
        reg_sel = 2'd1; #1;
        check(rdata1 == 8'h08, "R7", rdata1, 8'h08);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = '1; dat_addr = 8'h23; dat_wr = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; dat_wr = 1'b0; #1;
        check(rdata1 == 8'h02, "R7", rdata1, 8'h02);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule